// File: doc/BRIEF.md
# Configurable Power-Good Output Generator

This block turns per-rail supply-monitor comparator flags into one power-good pin. Each rail brings an undervoltage flag, an overvoltage flag and a monitor-enable bit. A microsecond tick clocks two debounce timers. A rail that goes bad is reported after a short fixed filter. A rail that comes good is reported after either the same short time or a long settling time. The pin shows either the live filtered status of all enabled rails or a sticky record of per-rail faults. Software clears that record with write-one-to-clear pulses.

A six-bit control word sets several things: the monitoring window (UV only, or UV and OV), the long rise delay, the source mode, the polarity and the drive type. It also sets whether rail 0's power-good is merged into an active-low interrupt line. Comparators, register decoding and regulator sequencing sit outside the block. There is no data stream here, so every pin is a plain control or status signal with no valid/ready handshake.

Top module: `pgood_gen`

## Requirements
- R1: While `rst_n` is low: `pg_out`=0, `pg_oe`=0, `irq_out_n`=1 and every `rail_fault` bit is 1. Every rail's filtered status resets to invalid. After the first clock edge following reset, with `cfg_word`=0, the pin reads 0 with `pg_oe`=1.
- R2: Rail validity depends on `cfg_word[2]` (window). With window=0, only the UV flag makes a rail invalid and the OV flag has no effect. With window=1, either flag makes it invalid.
- R3: An invalid-to-valid change is accepted on the tick that completes a run of consecutive valid ticks. The run is 8 ticks when `cfg_word[4]`=0 and 11000 ticks when it is 1. The pin reflects the change one clock later.
- R4: A valid-to-invalid change is accepted after 8 consecutive invalid ticks, whatever the value of `cfg_word[4]`.
- R5: Any clock cycle in which a rail's raw state equals its filtered state restarts that rail's count from zero.
- R6: A rail with its enable bit at 0 counts as valid. It does not affect the live result, the latched result or the merge.
- R7: `cfg_word[3]`=1 selects latched mode. In this mode the level is valid only if no enabled rail has `rail_fault`=1. A rail's `rail_fault` bit goes to 1 in the cycle its filtered status falls.
- R8: A `flt_clr[i]` pulse clears `rail_fault[i]` only when the rail is currently filtered-valid and is not falling in that same cycle. Otherwise the pulse is ignored.
- R9: `cfg_word[0]`=0 makes the level 1 when all enabled rails are valid. `cfg_word[0]`=1 inverts the level.
- R10: `cfg_word[1]`=0 selects push-pull: `pg_oe`=1 and `pg_out`=level. `cfg_word[1]`=1 selects open-drain: `pg_out`=0 and `pg_oe`=NOT level, so the pin is driven only low.
- R11: `cfg_word[5]`=1 drives `irq_out_n` low when `irq_in_n` is low or when rail 0 is filtered-invalid while enabled. `cfg_word[5]`=0 passes `irq_in_n` through.
- R12: `pg_out`, `pg_oe` and `irq_out_n` are registered. Each reflects state, configuration and inputs one clock edge after those are sampled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rst_n | input | 1 | asynchronous active-low reset |
| us_tick | input | 1 | one-cycle microsecond tick |
| cfg_word | input | 6 | control word (bit fields in R2-R11) |
| rail_uv | input | N_RAILS | undervoltage flags |
| rail_ov | input | N_RAILS | overvoltage flags |
| rail_en | input | N_RAILS | monitor enables |
| flt_clr | input | N_RAILS | write-one-to-clear pulses for fault bits |
| irq_in_n | input | 1 | incoming active-low interrupt |
| pg_out | output | 1 | power-good data level |
| pg_oe | output | 1 | power-good output enable |
| irq_out_n | output | 1 | merged active-low interrupt |
| rail_fault | output | N_RAILS | latched per-rail fault record |

## Verification
A filtered status changes on the clock edge that samples the eighth, or the 11000th, qualifying tick. The pin shows that change one edge later. A fault bit changes on the very edge where the status falls or a valid clear is sampled. The bench drives inputs on the falling edge and samples outputs on the next falling edge. Directed checks count edges exactly to these numbers. A cycle-level reference model built from the requirements runs on the rising edge and is compared with every output at every falling edge. This covers the mixed random traffic.

// File: rtl/pgood_pkg.sv
package pgood_pkg;
  localparam int CFG_W       = 6;
  localparam int CFG_INVERT  = 0;
  localparam int CFG_OPEN_DR = 1;
  localparam int CFG_WINDOW  = 2;
  localparam int CFG_LATCHED = 3;
  localparam int CFG_LONGSET = 4;
  localparam int CFG_MERGE   = 5;

  typedef struct packed {
    logic merge_irq;
    logic long_set;
    logic latched;
    logic window;
    logic open_drain;
    logic invert;
  } pg_cfg_t;

  function automatic pg_cfg_t decode_cfg(input logic [CFG_W-1:0] w);
    pg_cfg_t c;
    c.invert     = w[CFG_INVERT];
    c.open_drain = w[CFG_OPEN_DR];
    c.window     = w[CFG_WINDOW];
    c.latched    = w[CFG_LATCHED];
    c.long_set   = w[CFG_LONGSET];
    c.merge_irq  = w[CFG_MERGE];
    return c;
  endfunction

  // Disabled rails read as valid; OV counts only inside window mode.
  function automatic logic rail_raw_ok(input logic en, input logic uv,
                                       input logic ov, input logic window);
    return !en || (!uv && !(window && ov));
  endfunction
endpackage

// File: rtl/pgood_rail_filter.sv
module pgood_rail_filter
  import pgood_pkg::*;
#(
  parameter int SHORT_US = 8,
  parameter int LONG_US  = 11000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic en,
  input  logic uv,
  input  logic ov,
  input  logic window,
  input  logic long_set,
  output logic good_q,
  output logic fall_evt
);
  localparam int MAX_US = (LONG_US > SHORT_US) ? LONG_US : SHORT_US;
  localparam int CNT_W  = $clog2(MAX_US + 1);
  localparam logic [CNT_W-1:0] SHORT_LAST = CNT_W'(SHORT_US - 1);
  localparam logic [CNT_W-1:0] LONG_LAST  = CNT_W'(LONG_US - 1);

  logic             raw_ok;
  logic             differs;
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] last;
  logic             flip;

  assign raw_ok  = rail_raw_ok(en, uv, ov, window);
  assign differs = (raw_ok != good_q);

  // falling edge always uses the short filter
  always_comb begin
    if (good_q) last = SHORT_LAST;
    else        last = long_set ? LONG_LAST : SHORT_LAST;
  end

  assign flip     = differs && tick && (cnt_q == last);
  assign fall_evt = flip && good_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      good_q <= 1'b0;
    end else if (!differs) begin
      cnt_q  <= '0;
    end else if (tick) begin
      if (flip) begin
        cnt_q  <= '0;
        good_q <= ~good_q;
      end else begin
        cnt_q  <= cnt_q + 1'b1;
      end
    end
  end

  // R3
  rise_needs_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(good_q) |-> $past(raw_ok && tick));
  // R4
  fall_needs_invalid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(good_q) |-> $past(!raw_ok && tick));
  // R5
  restart_on_agree_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (raw_ok == good_q) |=> (cnt_q == '0));
endmodule

// File: rtl/pgood_fault_latch.sv
module pgood_fault_latch (
  input  logic clk,
  input  logic rst_n,
  input  logic fall_evt,
  input  logic good,
  input  logic clr,
  output logic fault_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                fault_q <= 1'b1;
    else if (fall_evt)         fault_q <= 1'b1;
    else if (clr && good)      fault_q <= 1'b0;
  end

  // R7
  fall_sets_fault_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fall_evt |=> fault_q);
  // R8
  clear_only_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(fault_q) |-> $past(clr && good));
endmodule

// File: rtl/pgood_out_stage.sv
module pgood_out_stage
  import pgood_pkg::*;
#(
  parameter int N_RAILS = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  pg_cfg_t            cfg,
  input  logic [N_RAILS-1:0] en,
  input  logic [N_RAILS-1:0] good,
  input  logic [N_RAILS-1:0] fault,
  input  logic               irq_in_n,
  output logic               pg_out,
  output logic               pg_oe,
  output logic               irq_out_n
);
  logic all_live, all_clean, level, rail0_pg;
  logic pg_d, oe_d, irq_d;

  assign all_live  = &(~en | good);
  assign all_clean = &(~en | ~fault);
  assign level     = (cfg.latched ? all_clean : all_live) ^ cfg.invert;
  assign rail0_pg  = !en[0] || good[0];

  always_comb begin
    if (cfg.open_drain) begin
      pg_d = 1'b0;
      oe_d = ~level;
    end else begin
      pg_d = level;
      oe_d = 1'b1;
    end
    irq_d = irq_in_n && (!cfg.merge_irq || rail0_pg);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pg_out    <= 1'b0;
      pg_oe     <= 1'b0;
      irq_out_n <= 1'b1;
    end else begin
      pg_out    <= pg_d;
      pg_oe     <= oe_d;
      irq_out_n <= irq_d;
    end
  end

  // R10
  od_drives_low_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(cfg.open_drain)) |-> !pg_out);
  // R11
  irq_forced_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && !$past(irq_in_n)) |-> !irq_out_n);
  // R11
  irq_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && !$past(cfg.merge_irq)) |-> (irq_out_n == $past(irq_in_n)));
endmodule

// File: rtl/pgood_gen.sv
module pgood_gen
  import pgood_pkg::*;
#(
  parameter int N_RAILS  = 4,
  parameter int SHORT_US = 8,
  parameter int LONG_US  = 11000
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               us_tick,
  input  logic [CFG_W-1:0]   cfg_word,
  input  logic [N_RAILS-1:0] rail_uv,
  input  logic [N_RAILS-1:0] rail_ov,
  input  logic [N_RAILS-1:0] rail_en,
  input  logic [N_RAILS-1:0] flt_clr,
  input  logic               irq_in_n,
  output logic               pg_out,
  output logic               pg_oe,
  output logic               irq_out_n,
  output logic [N_RAILS-1:0] rail_fault
);
  pg_cfg_t            cfg;
  logic [N_RAILS-1:0] good;
  logic [N_RAILS-1:0] fall;

  assign cfg = decode_cfg(cfg_word);

  for (genvar i = 0; i < N_RAILS; i++) begin : g_rail
    pgood_rail_filter #(.SHORT_US(SHORT_US), .LONG_US(LONG_US)) u_filt (
      .clk      (clk),
      .rst_n    (rst_n),
      .tick     (us_tick),
      .en       (rail_en[i]),
      .uv       (rail_uv[i]),
      .ov       (rail_ov[i]),
      .window   (cfg.window),
      .long_set (cfg.long_set),
      .good_q   (good[i]),
      .fall_evt (fall[i])
    );
    pgood_fault_latch u_flt (
      .clk      (clk),
      .rst_n    (rst_n),
      .fall_evt (fall[i]),
      .good     (good[i]),
      .clr      (flt_clr[i]),
      .fault_q  (rail_fault[i])
    );
  end

  pgood_out_stage #(.N_RAILS(N_RAILS)) u_out (
    .clk       (clk),
    .rst_n     (rst_n),
    .cfg       (cfg),
    .en        (rail_en),
    .good      (good),
    .fault     (rail_fault),
    .irq_in_n  (irq_in_n),
    .pg_out    (pg_out),
    .pg_oe     (pg_oe),
    .irq_out_n (irq_out_n)
  );

  // R6
  disabled_rail_no_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fall & ~rail_en) == '0);
endmodule

// File: tb/pgood_gen_tb.sv
module pgood_gen_tb;
  localparam int CLK_PERIOD = 10;
  localparam int NR    = 4;
  localparam int SHORT = 8;
  localparam int LONG  = 11000;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          us_tick = 1'b1;
  logic [5:0]    cfg_word = '0;
  logic [NR-1:0] rail_uv = '0, rail_ov = '0, rail_en = '1, flt_clr = '0;
  logic          irq_in_n = 1'b1;
  logic          pg_out, pg_oe, irq_out_n;
  logic [NR-1:0] rail_fault;

  int checks = 0;
  int errors = 0;
  bit done   = 0;
  bit cmp_en = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pgood_gen #(.N_RAILS(NR), .SHORT_US(SHORT), .LONG_US(LONG)) u_dut (
    .clk(clk), .rst_n(rst_n), .us_tick(us_tick), .cfg_word(cfg_word),
    .rail_uv(rail_uv), .rail_ov(rail_ov), .rail_en(rail_en), .flt_clr(flt_clr),
    .irq_in_n(irq_in_n), .pg_out(pg_out), .pg_oe(pg_oe), .irq_out_n(irq_out_n),
    .rail_fault(rail_fault));

  // reference model, built from the requirements
  logic          m_good [NR];
  int            m_cnt  [NR];
  logic [NR-1:0] m_flt;
  logic          e_pg, e_oe, e_irq;

  function automatic logic f_raw(input logic en, input logic uv, input logic ov, input logic win);
    return !en || (!uv && !(win && ov));
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NR; i++) begin m_good[i] = 0; m_cnt[i] = 0; end
      m_flt = '1; e_pg = 0; e_oe = 0; e_irq = 1;
    end else begin
      logic live, clean, lvl, pg0;
      live = 1; clean = 1;
      for (int i = 0; i < NR; i++) begin
        if (rail_en[i] && !m_good[i]) live = 0;
        if (rail_en[i] && m_flt[i])   clean = 0;
      end
      lvl  = (cfg_word[3] ? clean : live) ^ cfg_word[0];
      e_pg = cfg_word[1] ? 1'b0 : lvl;
      e_oe = cfg_word[1] ? ~lvl : 1'b1;
      pg0  = !rail_en[0] || m_good[0];
      e_irq = irq_in_n && (!cfg_word[5] || pg0);
      for (int i = 0; i < NR; i++) begin
        logic raw, fl, ng;
        int lim;
        raw = f_raw(rail_en[i], rail_uv[i], rail_ov[i], cfg_word[2]);
        fl = 0; ng = m_good[i];
        if (raw == m_good[i]) m_cnt[i] = 0;
        else if (us_tick) begin
          lim = m_good[i] ? SHORT : (cfg_word[4] ? LONG : SHORT);
          if (m_cnt[i] == lim - 1) begin
            fl = m_good[i]; ng = ~m_good[i]; m_cnt[i] = 0;
          end else m_cnt[i] = m_cnt[i] + 1;
        end
        if (fl) m_flt[i] = 1'b1;
        else if (flt_clr[i] && m_good[i]) m_flt[i] = 1'b0;
        m_good[i] = ng;
      end
    end
  end

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (cmp_en && rst_n && !done) begin
      check("R12 model pg_out", pg_out, e_pg);
      check("R12 model pg_oe", pg_oe, e_oe);
      check("R12 model irq_out_n", irq_out_n, e_irq);
      check("R12 model rail_fault", rail_fault, m_flt);
    end
  end

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic finish_run();
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=timeout expected=completion");
      finish_run();
    end
  end

  initial begin
    void'($urandom(32'd2024));
    step(3);
    // R1 reset state
    check("R1 pg_out in reset", pg_out, 0);
    check("R1 pg_oe in reset", pg_oe, 0);
    check("R1 irq_out_n in reset", irq_out_n, 1);
    check("R1 rail_fault in reset", rail_fault, 4'hF);
    rst_n = 1'b1;
    cmp_en = 1;
    step(1);
    check("R1 first edge pg_oe", pg_oe, 1);
    check("R1 first edge pg_out", pg_out, 0);
    step(7);
    check("R3 short rise not yet", pg_out, 0);
    step(1);
    check("R3 short rise done", pg_out, 1);
    // R5 restart on a single valid sample
    rail_uv[2] = 1; step(7);
    rail_uv[2] = 0; step(1);
    rail_uv[2] = 1; step(8);
    check("R5 restart holds output", pg_out, 1);
    step(1);
    check("R4 fall after 8 ticks", pg_out, 0);
    rail_uv[2] = 0; step(10);
    check("R3 recovered", pg_out, 1);
    // R2 window
    rail_ov[1] = 1; step(20);
    check("R2 OV ignored without window", pg_out, 1);
    cfg_word[2] = 1; step(9);
    check("R2 OV invalid with window", pg_out, 0);
    // R6 disabled rail
    rail_en[1] = 0; step(1);
    check("R6 disabled rail excluded", pg_out, 1);
    rail_ov[1] = 0; rail_en[1] = 1; step(10);
    check("R6 re-enabled rail good", pg_out, 1);
    // R9 R10
    cfg_word[0] = 1; step(1);
    check("R9 inverted level", pg_out, 0);
    cfg_word[1] = 1; step(1);
    check("R10 od low drives", {pg_out, pg_oe}, 2'b01);
    cfg_word[0] = 0; step(1);
    check("R10 od releases", {pg_out, pg_oe}, 2'b00);
    cfg_word[1] = 0; step(1);
    check("R10 push-pull", {pg_out, pg_oe}, 2'b11);
    // R7 R8 latched mode
    cfg_word[3] = 1; step(1);
    check("R7 latched faults from reset", pg_out, 0);
    flt_clr = '1; step(1); flt_clr = '0;
    check("R8 clear valid rails", rail_fault, 4'h0);
    step(1);
    check("R7 clean after clear", pg_out, 1);
    rail_uv[3] = 1; step(9);
    check("R7 fault latched", rail_fault, 4'h8);
    check("R7 latched output", pg_out, 0);
    flt_clr[3] = 1; step(1); flt_clr[3] = 0;
    check("R8 clear ignored while invalid", rail_fault, 4'h8);
    rail_uv[3] = 0; step(10);
    check("R7 sticky after recovery", pg_out, 0);
    flt_clr[3] = 1; step(1); flt_clr[3] = 0;
    check("R8 clear when valid", rail_fault, 4'h0);
    step(1);
    check("R7 output after clear", pg_out, 1);
    // R3 R4 long setting
    cfg_word[3] = 0; cfg_word[4] = 1;
    rail_uv[0] = 1; step(9);
    check("R4 fall unaffected by long", pg_out, 0);
    rail_uv[0] = 0; step(LONG);
    check("R3 long rise not yet", pg_out, 0);
    step(1);
    check("R3 long rise done", pg_out, 1);
    // R11 merge
    cfg_word[4] = 0; cfg_word[5] = 1; step(1);
    check("R11 merge rail0 good", irq_out_n, 1);
    rail_uv[0] = 1; step(9);
    check("R11 merge rail0 bad", irq_out_n, 0);
    cfg_word[5] = 0; step(1);
    check("R11 pass-through", irq_out_n, 1);
    irq_in_n = 0; step(1);
    check("R11 pass low", irq_out_n, 0);
    irq_in_n = 1; rail_uv[0] = 0; step(10);
    // random mix, checked by the model every cycle
    for (int seg = 0; seg < 30; seg++) begin
      cfg_word = 6'($urandom) & (($urandom % 8 == 0) ? 6'h3F : 6'h2F);
      for (int c = 0; c < 400; c++) begin
        us_tick = ($urandom % 3) != 0;
        for (int i = 0; i < NR; i++) begin
          if ($urandom % 32 == 0) rail_uv[i] = ~rail_uv[i];
          if ($urandom % 32 == 0) rail_ov[i] = ~rail_ov[i];
          if ($urandom % 200 == 0) rail_en[i] = ~rail_en[i];
          flt_clr[i] = ($urandom % 16 == 0);
        end
        if ($urandom % 8 == 0) irq_in_n = ~irq_in_n;
        step(1);
      end
    end
    finish_run();
  end
endmodule